// File: doc/BRIEF.md
# Bridge PWM Generator with Dead-Band and Fault Shutdown

This block turns one pulse-width-modulated waveform into up to four pin drives, labelled A, B, C and D, which can steer a single load, a half bridge or a full H-bridge. A 10-bit fine counter sets the period. An 8-bit period value selects where the counter wraps, and a 10-bit duty value is compared against the counter. A prescaler slows the counter by 1, 4 or 16. Each output pair (A/C and B/D) has its own polarity. In half-bridge mode the block inserts a programmable dead time. During this time both switches of the leg are held off before either one turns on.

Three fault sources can be enabled one at a time. While a shutdown is latched, each pin pair goes to its own safe level: low, high or released. The shutdown ends either automatically once the faults are gone, or when software writes a clear. Normal drive returns only when the next period begins. Software configures everything through an 8-bit write port. The pins come out as a value vector and an output-enable vector.

Top module: `pwm_bridge`

## Requirements
- R1: The fine counter advances once per prescaler tick. Its period ends on the tick where it has reached {period, 2'b11}, and it then restarts at 0. One period is therefore (period+1)*4 ticks. Register address 0 holds the period.
- R2: The duty value is {address 1, address 2 bits [1:0]}. An output is active while fine count < duty, so a duty at or above the period length gives an output that is active for the whole period. A new duty value takes effect at the next period start.
- R3: Address 2 bits [7:6] select the prescaler: 00 gives 1:1, 01 gives 1:4, and 10 or 11 give 1:16 clock cycles per tick.
- R4: Address 2 bits [3:2] select the steering. In 00 (single), A is driven with the waveform. In 10 (half bridge), A carries the waveform and B its complement. In 01 (forward), A is held active and D carries the waveform. In 11 (reverse), C is held active and B carries the waveform. Single mode enables only A, half-bridge mode enables only A and B, and both full-bridge modes enable all four pins.
- R5: Address 2 bit 4 inverts pins A and C, and bit 5 inverts pins B and D (1 = active-low).
- R6: In half-bridge mode, each turn-on of A or B is delayed by the 7-bit value in address 3 bits [6:0] clock cycles. A and B are never active together.
- R7: Address 4 bits [2:0] enable fault sources fault_in[0..2] (active-high). An enabled active source sets sd_active and forces the pins to their shutdown levels one clock later. A disabled source has no effect.
- R8: During shutdown, pins A/C take the level coded in address 4 bits [4:3] and pins B/D take the level coded in bits [6:5]. The codes are 00 = drive low, 01 = drive high, and 1x = released (output enable low).
- R9: With auto-restart off, sd_active stays set until a write to address 5. That write has no effect while an enabled source is still active.
- R10: With auto-restart on (address 3 bit 7), sd_active clears on the clock after no enabled source is active.
- R11: After sd_active clears, the pins keep their shutdown levels until the next period start. They then resume normal drive.
- R12: Reset clears every register and sd_active. The run bit (address 4 bit 7) is therefore 0 after reset, and while run is 0 the counter stays at 0 and all output enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| fault_in | input | 3 | Fault sources, active high |
| pin_out | output | 4 | Pin values, bit 0 = A ... bit 3 = D |
| pin_oe | output | 4 | Pin output enables, 0 = released |
| sd_active | output | 1 | Shutdown status |

## Verification
Several properties are checked on every cycle. An enabled fault always latches shutdown on the next clock. Without auto-restart and without a clear, a latched shutdown never lapses. The resume flag only falls where the counter restarts at zero. The half-bridge pins both go idle across a dead-band edge. A stopped block never enables a pin. With a 1:1 prescaler, the counter steps by one each clock. Other behaviours show up only in the bench's scenarios: the active-cycle count per period for each mode, polarity and prescaler, the dead time subtracted from each half-bridge phase, the shutdown levels, and the delay of resumption to the period boundary.

// File: rtl/pwm_bridge_pkg.sv
// Package: shared widths, register addresses, steering modes and the
// configuration record for the bridge PWM generator.
package pwm_bridge_pkg;
    localparam int PER_W  = 8;                 // period register width
    localparam int FINE_W = 2;                 // sub-period fraction bits
    localparam int CNT_W  = PER_W + FINE_W;    // fine counter / duty width
    localparam int DB_W   = 7;                 // dead-band count width
    localparam int NSRC   = 3;                 // fault sources
    localparam int NPIN   = 4;                 // output pins A..D
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int PRE_W  = 4;                 // prescaler counter width (max 1:16)

    localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DUTY   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_DBAND  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_FAULT  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(5);

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_FWD    = 2'b01,
        MODE_HALF   = 2'b10,
        MODE_REV    = 2'b11
    } steer_mode_e;

    typedef struct packed {
        logic [PER_W-1:0]  period;
        logic [PER_W-1:0]  duty_hi;
        logic [FINE_W-1:0] duty_lo;
        steer_mode_e       mode;
        logic              inv_ac;
        logic              inv_bd;
        logic [1:0]        presc;
        logic [DB_W-1:0]   db;
        logic              auto_rst;
        logic [NSRC-1:0]   src_en;
        logic [1:0]        ss_ac;
        logic [1:0]        ss_bd;
        logic              run;
    } cfg_t;
endpackage

// File: rtl/pwm_bridge_regs.sv
// Register file: decodes the write port into the configuration record.
// Assumes one write per cycle; address 5 yields a one-cycle clear request
// and stores nothing.
module pwm_bridge_regs
    import pwm_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              clr_req
);
    // Store written fields; everything returns to zero on reset.
    always_ff @(posedge clk) begin : p_write
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PERIOD: cfg.period <= wr_data[PER_W-1:0];
                A_DUTY:   cfg.duty_hi <= wr_data[PER_W-1:0];
                A_CTRL: begin
                    cfg.duty_lo <= wr_data[1:0];
                    cfg.mode    <= steer_mode_e'(wr_data[3:2]);
                    cfg.inv_ac  <= wr_data[4];
                    cfg.inv_bd  <= wr_data[5];
                    cfg.presc   <= wr_data[7:6];
                end
                A_DBAND: begin
                    cfg.db       <= wr_data[DB_W-1:0];
                    cfg.auto_rst <= wr_data[7];
                end
                A_FAULT: begin
                    cfg.src_en <= wr_data[NSRC-1:0];
                    cfg.ss_ac  <= wr_data[4:3];
                    cfg.ss_bd  <= wr_data[6:5];
                    cfg.run    <= wr_data[7];
                end
                default: ;
            endcase
        end
    end

    // Software clear of the shutdown status is a write strobe only.
    assign clr_req = wr_en && (wr_addr == A_CLEAR);
endmodule

// File: rtl/pwm_bridge_timebase.sv
// Timebase: prescaled fine counter, period wrap, duty latch at period
// start, and the raw PWM comparison. Assumes run low holds it at zero.
module pwm_bridge_timebase
    import pwm_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic [1:0]       presc,
    output logic             pstart,
    output logic [CNT_W-1:0] fcnt,
    output logic             pwm
);
    localparam logic [PRE_W-1:0] DIV4_M1  = PRE_W'(3);
    localparam logic [PRE_W-1:0] DIV16_M1 = '1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic [CNT_W-1:0] duty_q;
    logic             tick;

    // Map the prescaler code to its terminal count.
    always_comb begin : p_lim
        case (presc)
            2'b00:   pre_lim = '0;
            2'b01:   pre_lim = DIV4_M1;
            default: pre_lim = DIV16_M1;
        endcase
    end

    assign tick   = run && (pre_cnt >= pre_lim);
    assign pstart = tick && (fcnt >= {period, {FINE_W{1'b1}}});

    // Advance prescaler and fine counter; reload duty at each period start.
    always_ff @(posedge clk) begin : p_count
        if (!rst_n) begin
            pre_cnt <= '0;
            fcnt    <= '0;
            duty_q  <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
            fcnt    <= '0;
            duty_q  <= duty;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick) fcnt <= pstart ? '0 : fcnt + 1'b1;
            if (pstart) duty_q <= duty;
        end
    end

    assign pwm = run && (fcnt < duty_q);

    // R3: at 1:1 the counter moves by one on every running clock.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && presc == 2'b00 && $past(presc) == 2'b00 && !$past(pstart))
        |-> fcnt == $past(fcnt) + 1'b1);
endmodule

// File: rtl/pwm_bridge_fault.sv
// Fault latch: sets shutdown from any enabled source, clears it by
// auto-restart or software, and holds the pins in shutdown until the
// next period start after the status clears.
module pwm_bridge_fault
    import pwm_bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fault_in,
    input  logic [NSRC-1:0] src_en,
    input  logic            auto_rst,
    input  logic            clr,
    input  logic            pstart,
    output logic            sd_stat,
    output logic            hold
);
    logic trig;
    logic sd_next;

    assign trig = |(fault_in & src_en);

    // Next shutdown status: a live fault wins over any clear.
    always_comb begin : p_next
        if (trig)                 sd_next = 1'b1;
        else if (auto_rst || clr) sd_next = 1'b0;
        else                      sd_next = sd_stat;
    end

    // Register status and the pin hold flag that waits for a period start.
    always_ff @(posedge clk) begin : p_state
        if (!rst_n) begin
            sd_stat <= 1'b0;
            hold    <= 1'b0;
        end else begin
            sd_stat <= sd_next;
            if (trig)                     hold <= 1'b1;
            else if (pstart && !sd_next)  hold <= 1'b0;
        end
    end

    // R7: an enabled fault latches status and pin hold on the next clock.
    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (sd_stat && hold));
    // R9: without auto-restart or a clear, shutdown persists.
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_stat && !auto_rst && !clr) |=> sd_stat);
endmodule

// File: rtl/pwm_bridge_steer.sv
// Output steering: dead-band timing, mode routing, per-pair polarity and
// shutdown levels. Assumes pwm is the raw comparison from the timebase.
module pwm_bridge_steer
    import pwm_bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pwm,
    input  steer_mode_e     mode,
    input  logic            inv_ac,
    input  logic            inv_bd,
    input  logic [DB_W-1:0] db,
    input  logic            shut,
    input  logic [1:0]      ss_ac,
    input  logic [1:0]      ss_bd,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    logic            pwm_q;
    logic [DB_W-1:0] db_cnt;
    logic            db_idle;
    logic [NPIN-1:0] act;
    logic [NPIN-1:0] used;

    // Register the waveform and start a dead-band count on each edge.
    always_ff @(posedge clk) begin : p_deadband
        if (!rst_n) begin
            pwm_q  <= 1'b0;
            db_cnt <= '0;
        end else begin
            pwm_q <= pwm;
            if (pwm != pwm_q)        db_cnt <= (mode == MODE_HALF) ? db : '0;
            else if (db_cnt != '0)   db_cnt <= db_cnt - 1'b1;
        end
    end

    assign db_idle = (db_cnt == '0);

    // Route the waveform to the pins the selected mode uses.
    always_comb begin : p_route
        act  = '0;
        used = '0;
        case (mode)
            MODE_SINGLE: begin
                act[0] = pwm_q;
                used   = NPIN'(4'b0001);
            end
            MODE_HALF: begin
                act[0] = pwm_q && db_idle;
                act[1] = !pwm_q && db_idle;
                used   = NPIN'(4'b0011);
            end
            MODE_FWD: begin
                act[0] = 1'b1;
                act[3] = pwm_q;
                used   = '1;
            end
            MODE_REV: begin
                act[2] = 1'b1;
                act[1] = pwm_q;
                used   = '1;
            end
            default: ;
        endcase
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        logic       inv;
        logic [1:0] ss;
        logic       o;
        logic       e;
        assign inv = (i % 2 == 1) ? inv_bd : inv_ac;
        assign ss  = (i % 2 == 1) ? ss_bd : ss_ac;

        // Choose released, shutdown level or polarised drive for this pin.
        always_comb begin : p_pin
            if (!run || !used[i]) begin
                e = 1'b0;
                o = 1'b0;
            end else if (shut) begin
                e = !ss[1];
                o = !ss[1] && ss[0];
            end else begin
                e = 1'b1;
                o = act[i] ^ inv;
            end
        end
        assign pin_out[i] = o;
        assign pin_oe[i]  = e;
    end

    // R6: across a half-bridge waveform edge with a dead time set, both legs are idle.
    p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALF && $past(mode) == MODE_HALF && pwm_q != $past(pwm_q)
         && db != '0 && $stable(db)) |-> (!act[0] && !act[1]));
endmodule

// File: rtl/pwm_bridge.sv
// Top: bridge PWM generator with dead-band and fault shutdown. Connects
// the register file, timebase, fault latch and output steering.
module pwm_bridge
    import pwm_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NSRC-1:0]   fault_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              sd_active
);
    cfg_t             cfg;
    logic             clr_req;
    logic             pstart;
    logic [CNT_W-1:0] fcnt;
    logic             pwm;
    logic             hold;

    pwm_bridge_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .clr_req(clr_req)
    );

    pwm_bridge_timebase u_tb (
        .clk(clk), .rst_n(rst_n), .run(cfg.run), .period(cfg.period),
        .duty({cfg.duty_hi, cfg.duty_lo}), .presc(cfg.presc),
        .pstart(pstart), .fcnt(fcnt), .pwm(pwm)
    );

    pwm_bridge_fault u_flt (
        .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .src_en(cfg.src_en),
        .auto_rst(cfg.auto_rst), .clr(clr_req), .pstart(pstart),
        .sd_stat(sd_active), .hold(hold)
    );

    pwm_bridge_steer u_st (
        .clk(clk), .rst_n(rst_n), .run(cfg.run), .pwm(pwm), .mode(cfg.mode),
        .inv_ac(cfg.inv_ac), .inv_bd(cfg.inv_bd), .db(cfg.db), .shut(hold),
        .ss_ac(cfg.ss_ac), .ss_bd(cfg.ss_bd), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R11: pins leave shutdown only where the counter has restarted.
    p_resume_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (fcnt == '0));
    // R12: a stopped block releases every pin.
    p_tri_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.run |-> (pin_oe == '0));
endmodule

// File: tb/sim_pwm_bridge.sv
module sim_pwm_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] fault_in = '0;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;
    logic       sd_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwm_bridge u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_in(fault_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .sd_active(sd_active)
    );

    typedef struct packed {
        logic [7:0]  per;
        logic [9:0]  duty;
        logic [1:0]  mode;
        logic        inv_ac;
        logic        inv_bd;
        logic [1:0]  presc;
        logic [6:0]  db;
        logic [15:0] len;
        logic [3:0]  oe;
        logic [15:0] ca;
        logic [15:0] cb;
        logic [15:0] cc;
        logic [15:0] cd;
    } vec_t;

    // Expected high cycles per pin over one period (len clocks).
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd9, 10'd13, 2'b00, 1'b0, 1'b0, 2'b00, 7'd0, 16'd40,  4'b0001, 16'd13, 16'd0,  16'd0,  16'd0},  // R1 R2 single
        '{8'd9, 10'd13, 2'b00, 1'b1, 1'b0, 2'b00, 7'd0, 16'd40,  4'b0001, 16'd27, 16'd0,  16'd0,  16'd0},  // R5 inverted A
        '{8'd4, 10'd7,  2'b00, 1'b0, 1'b0, 2'b01, 7'd0, 16'd80,  4'b0001, 16'd28, 16'd0,  16'd0,  16'd0},  // R3 1:4
        '{8'd2, 10'd5,  2'b00, 1'b0, 1'b0, 2'b11, 7'd0, 16'd192, 4'b0001, 16'd80, 16'd0,  16'd0,  16'd0},  // R3 1:16 (code 11)
        '{8'd9, 10'd20, 2'b10, 1'b0, 1'b0, 2'b00, 7'd3, 16'd40,  4'b0011, 16'd17, 16'd17, 16'd0,  16'd0},  // R6 dead-band
        '{8'd9, 10'd10, 2'b10, 1'b0, 1'b1, 2'b00, 7'd0, 16'd40,  4'b0011, 16'd10, 16'd10, 16'd0,  16'd0},  // R4 R5 half, B inverted
        '{8'd9, 10'd13, 2'b01, 1'b0, 1'b0, 2'b00, 7'd0, 16'd40,  4'b1111, 16'd40, 16'd0,  16'd0,  16'd13}, // R4 forward
        '{8'd9, 10'd13, 2'b11, 1'b0, 1'b0, 2'b00, 7'd0, 16'd40,  4'b1111, 16'd0,  16'd13, 16'd40, 16'd0},  // R4 reverse
        '{8'd9, 10'd60, 2'b00, 1'b0, 1'b0, 2'b00, 7'd0, 16'd40,  4'b0001, 16'd40, 16'd0,  16'd0,  16'd0},  // R2 duty past period
        '{8'd9, 10'd0,  2'b00, 1'b0, 1'b0, 2'b00, 7'd0, 16'd40,  4'b0001, 16'd0,  16'd0,  16'd0,  16'd0}   // R2 zero duty
    };

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin : main
        int cnt [4];
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 oe in reset", int'(pin_oe), 0);
        check("R12 sd in reset", int'(sd_active), 0);
        rst_n = 1'b1;
        wr(3'd2, 8'h00);
        check("R12 oe while stopped", int'(pin_oe), 0);

        // Vector table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VECS[v].per);
            wr(3'd1, VECS[v].duty[9:2]);
            wr(3'd2, {VECS[v].presc, VECS[v].inv_bd, VECS[v].inv_ac, VECS[v].mode, VECS[v].duty[1:0]});
            wr(3'd3, {1'b0, VECS[v].db});
            wr(3'd4, 8'h80);
            repeat (3 * int'(VECS[v].len)) @(negedge clk);
            for (int p = 0; p < 4; p++) cnt[p] = 0;
            for (int c = 0; c < int'(VECS[v].len); c++) begin
                @(negedge clk);
                for (int p = 0; p < 4; p++) cnt[p] += int'(pin_out[p]);
            end
            check($sformatf("R4 vec%0d oe", v), int'(pin_oe), int'(VECS[v].oe));
            check($sformatf("R1 R2 R3 R5 vec%0d pinA", v), cnt[0], int'(VECS[v].ca));
            check($sformatf("R4 R6 vec%0d pinB", v), cnt[1], int'(VECS[v].cb));
            check($sformatf("R4 vec%0d pinC", v), cnt[2], int'(VECS[v].cc));
            check($sformatf("R4 vec%0d pinD", v), cnt[3], int'(VECS[v].cd));
        end

        // Fault handling in forward mode, no auto-restart
        wr(3'd0, 8'd9);
        wr(3'd1, 8'd3);
        wr(3'd2, 8'b00_0_0_01_01);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h8A);            // run, ss_bd=00, ss_ac=01, source 1 enabled
        repeat (100) @(negedge clk);
        fault_in = 3'b100;          // disabled source
        repeat (2) @(negedge clk);
        check("R7 disabled source sd", int'(sd_active), 0);
        check("R7 disabled source oe", int'(pin_oe), 15);
        fault_in = 3'b010;
        @(negedge clk);
        check("R7 enabled source sd", int'(sd_active), 1);
        check("R8 shutdown levels", int'(pin_out), 5);
        check("R8 shutdown oe", int'(pin_oe), 15);
        wr(3'd5, 8'h00);
        check("R9 clear ignored while active", int'(sd_active), 1);
        fault_in = 3'b000;
        repeat (100) @(negedge clk);
        check("R9 status kept", int'(sd_active), 1);
        check("R9 levels kept", int'(pin_out), 5);
        wr(3'd5, 8'h00);
        check("R9 software clear", int'(sd_active), 0);
        repeat (45) @(negedge clk);
        check("R11 resumed pin C", int'(pin_out[2]), 0);
        check("R11 resumed pin A", int'(pin_out[0]), 1);

        // Released shutdown levels
        wr(3'd4, 8'hDA);            // ss_bd=10, ss_ac=11
        fault_in = 3'b010;
        @(negedge clk);
        check("R8 released oe", int'(pin_oe), 0);
        fault_in = 3'b000;
        wr(3'd5, 8'h00);
        repeat (45) @(negedge clk);
        check("R11 drive back", int'(pin_oe), 15);

        // Auto-restart with resume at the period boundary
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h00);            // single, duty 0, 1:1
        wr(3'd3, 8'h80);            // auto-restart
        wr(3'd4, 8'h0A);            // stop
        wr(3'd4, 8'h8A);            // start: counter is 0 here
        repeat (5) @(negedge clk);  // count 5
        fault_in = 3'b010;
        @(negedge clk);             // count 6
        check("R7 auto sd set", int'(sd_active), 1);
        check("R8 high level", int'(pin_out[0]), 1);
        repeat (4) @(negedge clk);  // count 10
        fault_in = 3'b000;
        @(negedge clk);             // count 11
        check("R10 auto clear", int'(sd_active), 0);
        check("R11 held after clear", int'(pin_out[0]), 1);
        repeat (19) @(negedge clk); // count 30
        check("R11 held mid period", int'(pin_out[0]), 1);
        repeat (12) @(negedge clk); // count 42
        check("R11 resumed at boundary", int'(pin_out[0]), 0);

        // Reset in the middle of a shutdown
        wr(3'd3, 8'h00);
        fault_in = 3'b010;
        repeat (2) @(negedge clk);
        fault_in = 3'b000;
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 sd after reset", int'(sd_active), 0);
        check("R12 oe after reset", int'(pin_oe), 0);
        rst_n = 1'b1;
        wr(3'd4, 8'h80);
        repeat (3) @(negedge clk);
        check("R12 registers cleared oe", int'(pin_oe), 1);
        check("R12 registers cleared pin", int'(pin_out), 0);
        wr(3'd4, 8'h00);
        check("R12 stop releases", int'(pin_oe), 0);

        finish_run();
    end
endmodule